// File: doc/BRIEF.md
# Run-Time Configurable Reed-Solomon Burst Encoder

This block adds Reed-Solomon protection to the bursts of a transmitter. It works over GF(256) and the code is systematic. Message bytes enter as a stream with a first-byte marker and a last-byte marker. They leave at once and unchanged. A remainder register divides the message by the generator polynomial while the bytes pass. After the last message byte the block sends 2t parity bytes from that register, and the source is held off while it does so.

Two inputs shape each burst. The correction strength t may be 0 to 10, and a protection enable can switch parity off. The message length K is set by where the source places the last-byte marker. The caller keeps K within 16 to 255 − 2t, so that a codeword never holds more than 255 bytes. The block reads t and the enable only when it accepts the first byte of a burst. The source may therefore change them while the previous burst is still draining. With t = 0 or the enable low the block is a plain pass-through.

Top module: `rs_prog_encoder`

## Requirements
- R1: After reset no output is valid and no burst is open. While `in_sop` is low, `in_ready` is high.
- R2: Message bytes reach `out_data` unchanged and in order. `out_sop` is high on the first of them.
- R3: The field is generated by x^8+x^4+x^3+x^2+1 (low byte 0x1D). The generator is the product of (x+α^i) for i = 0 … 2t−1, with α = 0x02. Every emitted codeword, read first byte as the highest power, evaluates to zero at each of these 2t roots.
- R4: Exactly 2t parity bytes follow the last message byte, highest-degree remainder coefficient first. `out_eop` is high on the last parity byte only.
- R5: `cfg_t` and `cfg_fec_en` are sampled only when the first byte of a burst is accepted. Changes at any other time do not affect the burst in progress.
- R6: `in_ready` is low in every cycle in which a parity byte is being offered.
- R7: While `out_ready` is low, a parity byte on the output stays valid and unchanged. During the message phase `in_ready` follows `out_ready`.
- R8: With `cfg_t` = 0 or `cfg_fec_en` low, no parity is appended and `out_eop` marks the last message byte.
- R9: A `cfg_t` value above 10 behaves as t = 10.
- R10: A byte offered outside a burst without `in_sop` is consumed (`in_ready` high) and dropped (`out_valid` low).
- R11: A maximum-length codeword (K = 235, t = 10, 255 bytes) is encoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_t | input | 4 | Correction strength t for the next burst |
| cfg_fec_en | input | 1 | Parity enable for the next burst |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Message byte |
| in_sop | input | 1 | First byte of a burst |
| in_eop | input | 1 | Last byte of a burst |
| in_ready | output | 1 | Block accepts the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Codeword byte |
| out_sop | output | 1 | First codeword byte |
| out_eop | output | 1 | Last codeword byte |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
The in-line properties watch the control behaviour on every cycle. They check that the input is stalled during parity output and that a stalled parity byte holds its value. They also check that the latched strength stays fixed inside a burst, that the last message byte of a protected burst leads into parity, and that a closing byte returns the block to idle. Only the bench scenarios can show that the parity values themselves are right. For this the bench uses a long-division model and a root evaluation of each codeword. The scenarios also cover the pass-through cases, strength clamping, the maximum-length codeword, mid-burst configuration changes and dropped stray bytes.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
    localparam int SYM_W     = 8;
    localparam int MAX_T     = 10;
    localparam int MAX_ROOTS = 2 * MAX_T;
    localparam int T_W       = $clog2(MAX_T + 1);
    localparam int CNT_W     = $clog2(MAX_ROOTS + 1);
    localparam logic [SYM_W-1:0] FIELD_LOW = 8'h1D;  // x^4+x^3+x^2+1 below x^8

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [MAX_ROOTS-1:0][SYM_W-1:0] coef_vec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MSG  = 2'd1,
        ST_PAR  = 2'd2
    } enc_st_e;

    // Shift-and-add product in GF(2^8)
    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? FIELD_LOW : sym_t'(0));
        end
        return acc;
    endfunction

    function automatic sym_t gf_alpha_pow(int e);
        sym_t r;
        r = 8'h01;
        for (int i = 0; i < MAX_ROOTS; i++) begin
            if (i < e) r = gf_mul(r, 8'h02);
        end
        return r;
    endfunction

    // Non-leading coefficients of prod_{i<nroots} (x + alpha^i), ascending degree
    function automatic coef_vec_t gen_coeffs(int nroots);
        logic [MAX_ROOTS:0][SYM_W-1:0] g;
        sym_t root;
        g    = '0;
        g[0] = 8'h01;
        for (int i = 0; i < MAX_ROOTS; i++) begin
            if (i < nroots) begin
                root = gf_alpha_pow(i);
                for (int j = MAX_ROOTS; j > 0; j--) begin
                    g[j] = g[j-1] ^ gf_mul(g[j], root);
                end
                g[0] = gf_mul(g[0], root);
            end
        end
        return g[MAX_ROOTS-1:0];
    endfunction
endpackage

// File: rtl/rs_gen_mult.sv
module rs_gen_mult
    import rs_enc_pkg::*;
(
    input  sym_t             fb,
    input  logic [T_W-1:0]   t_sel,
    output coef_vec_t        prod
);
    coef_vec_t bank [MAX_T+1];

    assign bank[0] = '0;

    for (genvar tt = 1; tt <= MAX_T; tt++) begin : g_t
        localparam coef_vec_t GEN = gen_coeffs(2 * tt);
        for (genvar i = 0; i < MAX_ROOTS; i++) begin : g_i
            if (i < 2 * tt) begin : g_used
                assign bank[tt][i] = gf_mul(fb, GEN[i]);
            end else begin : g_unused
                assign bank[tt][i] = '0;
            end
        end
    end

    always_comb begin
        prod = '0;
        if (int'(t_sel) <= MAX_T) prod = bank[t_sel];
    end
endmodule

// File: rtl/rs_parity_reg.sv
module rs_parity_reg
    import rs_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic             shift,
    input  sym_t             din,
    input  logic [CNT_W-1:0] nroots,
    input  coef_vec_t        prod,
    output sym_t             fb,
    output sym_t             head
);
    typedef struct packed {
        coef_vec_t par;
    } preg_t;

    preg_t r_d, r_q;

    always_comb begin
        head = '0;
        for (int i = 0; i < MAX_ROOTS; i++) begin
            if (int'(nroots) == i + 1) head = r_q.par[i];
        end
        fb  = din ^ (clear ? sym_t'(0) : head);
        r_d = r_q;
        if (load) begin
            r_d.par[0] = prod[0];
            for (int i = 1; i < MAX_ROOTS; i++) begin
                r_d.par[i] = (clear ? sym_t'(0) : r_q.par[i-1]) ^ prod[i];
            end
        end else if (shift) begin
            r_d.par[0] = '0;
            for (int i = 1; i < MAX_ROOTS; i++) begin
                r_d.par[i] = r_q.par[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R6: division and parity shifting never overlap
    p_no_load_while_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
    import rs_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [T_W-1:0]   cfg_t,
    input  logic             cfg_fec_en,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop,
    output logic             par_sel,
    output logic             lfsr_load,
    output logic             lfsr_clear,
    output logic             lfsr_shift,
    output logic [T_W-1:0]   t_cur,
    output logic [CNT_W-1:0] nroots
);
    typedef struct packed {
        enc_st_e          st;
        logic [T_W-1:0]   t;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic [T_W-1:0] t_clamp, t_new;

    always_comb begin
        t_clamp = (int'(cfg_t) > MAX_T) ? T_W'(MAX_T) : cfg_t;
        t_new   = cfg_fec_en ? t_clamp : '0;
        t_cur   = (s_q.st == ST_IDLE) ? t_new : s_q.t;
        nroots  = CNT_W'({t_cur, 1'b0});

        s_d        = s_q;
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        out_sop    = 1'b0;
        out_eop    = 1'b0;
        par_sel    = 1'b0;
        lfsr_load  = 1'b0;
        lfsr_clear = 1'b0;
        lfsr_shift = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                in_ready  = in_sop ? out_ready : 1'b1;
                out_valid = in_valid && in_sop;
                out_sop   = 1'b1;
                out_eop   = in_eop && (t_new == '0);
                if (in_valid && in_sop && out_ready) begin
                    lfsr_load  = 1'b1;
                    lfsr_clear = 1'b1;
                    s_d.t      = t_new;
                    s_d.cnt    = '0;
                    if (in_eop) s_d.st = (t_new != '0) ? ST_PAR : ST_IDLE;
                    else        s_d.st = ST_MSG;
                end
            end
            ST_MSG: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_eop   = in_eop && (s_q.t == '0);
                if (in_valid && out_ready) begin
                    lfsr_load = 1'b1;
                    if (in_eop) s_d.st = (s_q.t != '0) ? ST_PAR : ST_IDLE;
                end
            end
            ST_PAR: begin
                out_valid = 1'b1;
                par_sel   = 1'b1;
                out_eop   = (s_q.cnt == CNT_W'(nroots - 1'b1));
                if (out_ready) begin
                    lfsr_shift = 1'b1;
                    s_d.cnt    = s_q.cnt + 1'b1;
                    if (out_eop) begin
                        s_d.st  = ST_IDLE;
                        s_d.cnt = '0;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= ST_IDLE;
            s_q.t   <= '0;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    p_stall_in_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_PAR) |-> !in_ready);

    p_t_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE) |=> $stable(s_q.t));

    p_parity_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_MSG && in_valid && in_ready && in_eop && s_q.t != '0)
        |=> (s_q.st == ST_PAR && s_q.cnt == '0));

    p_frame_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> (s_q.st == ST_IDLE));
endmodule

// File: rtl/rs_prog_encoder.sv
module rs_prog_encoder
    import rs_enc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  cfg_t,
    input  logic        cfg_fec_en,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sop,
    input  logic        in_eop,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_sop,
    output logic        out_eop,
    input  logic        out_ready
);
    logic             par_sel, lfsr_load, lfsr_clear, lfsr_shift;
    logic [T_W-1:0]   t_cur;
    logic [CNT_W-1:0] nroots;
    sym_t             fb, head;
    coef_vec_t        prod;

    rs_enc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_t      (cfg_t),
        .cfg_fec_en (cfg_fec_en),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .out_ready  (out_ready),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_sop    (out_sop),
        .out_eop    (out_eop),
        .par_sel    (par_sel),
        .lfsr_load  (lfsr_load),
        .lfsr_clear (lfsr_clear),
        .lfsr_shift (lfsr_shift),
        .t_cur      (t_cur),
        .nroots     (nroots)
    );

    rs_gen_mult u_mult (
        .fb    (fb),
        .t_sel (t_cur),
        .prod  (prod)
    );

    rs_parity_reg u_preg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (lfsr_load),
        .clear  (lfsr_clear),
        .shift  (lfsr_shift),
        .din    (in_data),
        .nroots (nroots),
        .prod   (prod),
        .fb     (fb),
        .head   (head)
    );

    assign out_data = par_sel ? head : in_data;

    p_parity_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/rs_prog_encoder_tb_top.sv
`timescale 1ns/1ps
module rs_prog_encoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_t = '0;
    logic       cfg_fec_en = 1'b0;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, out_valid, out_sop, out_eop;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;

    always #2.5 clk = ~clk;

    rs_prog_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_t(cfg_t), .cfg_fec_en(cfg_fec_en),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_ready(out_ready)
    );

    typedef struct packed {
        logic [7:0] d;
        logic       sop;
        logic       eop;
        logic       par;
        logic [4:0] nr;
    } exp_t;

    exp_t  q[$];
    string tq[$];
    int    n_chk = 0, n_fail = 0;
    logic  bp_en = 1'b0;
    logic [15:0] bp_lfsr = 16'hACE1;
    logic [7:0] msg [256];
    logic [7:0] work [300];
    logic [7:0] gasc [21];
    logic [7:0] cw_buf [300];
    int    cw_len = 0;
    logic  hold_v = 1'b0;
    logic [7:0] hold_d;
    exp_t  e_cur;
    string t_cur_tag;
    logic [7:0] syn;

    always @(posedge clk) begin
        #1;
        bp_lfsr   <= {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
        out_ready <= bp_en ? (bp_lfsr[0] | bp_lfsr[3]) : 1'b1;
    end

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011D << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] apow(input int e);
        logic [7:0] r = 8'h01;
        for (int i = 0; i < e; i++) r = bmul(r, 8'h02);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // software model: long division of m(x)*x^nr by the generator
    task automatic build_frame(input int k, input int tcfg, input bit en,
                               input int seed, input string tag);
        int tt, nr;
        logic [7:0] c;
        exp_t e;
        tt = en ? ((tcfg > 10) ? 10 : tcfg) : 0;
        nr = 2 * tt;
        for (int i = 0; i < k; i++) msg[i] = 8'((seed * 29 + i * i * 7 + i) ^ (i >> 1));
        for (int j = 0; j < 21; j++) gasc[j] = 8'h00;
        gasc[0] = 8'h01;
        for (int r = 0; r < nr; r++) begin
            for (int j = nr; j >= 1; j--) gasc[j] = gasc[j-1] ^ bmul(gasc[j], apow(r));
            gasc[0] = bmul(gasc[0], apow(r));
        end
        for (int i = 0; i < k + nr; i++) work[i] = (i < k) ? msg[i] : 8'h00;
        for (int i = 0; i < k; i++) begin
            c = work[i];
            for (int j = 1; j <= nr; j++) work[i+j] = work[i+j] ^ bmul(c, gasc[nr-j]);
        end
        for (int i = 0; i < k + nr; i++) begin
            e.d   = (i < k) ? msg[i] : work[i];
            e.sop = (i == 0);
            e.eop = (i == k + nr - 1);
            e.par = (i >= k);
            e.nr  = 5'(nr);
            q.push_back(e);
            tq.push_back(tag);
        end
    endtask

    task automatic put_byte(input logic [7:0] d, input logic s, input logic l);
        in_data = d; in_sop = s; in_eop = l; in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic send(input int k, input int tcfg, input bit en, input int seed,
                        input string tag, input bit mid_change);
        build_frame(k, tcfg, en, seed, tag);
        cfg_t = 4'(tcfg); cfg_fec_en = en;
        for (int i = 0; i < k; i++) begin
            put_byte(msg[i], i == 0, i == k - 1);
            if (i == 0 && mid_change) begin
                cfg_t = 4'd1; cfg_fec_en = ~en;   // R5: must not alter this burst
            end
        end
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        #1;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_v) begin
                check(out_valid && out_data == hold_d, "R7", "stalled parity byte", out_data, hold_d);
                hold_v = 1'b0;
            end
            if (q.size() > 0 && q[0].par && out_valid)
                check(!in_ready, "R6", "in_ready while parity offered", in_ready, 0);
            if (out_valid && !out_ready && q.size() > 0 && q[0].par) begin
                hold_v = 1'b1; hold_d = out_data;
            end
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    check(1'b0, "R10", "unexpected output byte", out_data, 0);
                end else begin
                    e_cur     = q.pop_front();
                    t_cur_tag = tq.pop_front();
                    check(out_data == e_cur.d, {t_cur_tag, e_cur.par ? " R4" : " R2"},
                          "data byte", out_data, e_cur.d);
                    check(out_sop == e_cur.sop && out_eop == e_cur.eop,
                          {t_cur_tag, " R4"}, "sop/eop markers",
                          {out_sop, out_eop}, {e_cur.sop, e_cur.eop});
                    cw_buf[cw_len] = out_data;
                    cw_len++;
                    if (e_cur.eop) begin
                        for (int r = 0; r < int'(e_cur.nr); r++) begin
                            syn = 8'h00;
                            for (int b = 0; b < cw_len; b++) syn = bmul(syn, apow(r)) ^ cw_buf[b];
                            check(syn == 8'h00, "R3", "codeword value at generator root", syn, 0);
                        end
                        cw_len = 0;
                    end
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready idle", in_ready, 1);

        send(16, 1, 1'b1, 3, "R2", 1'b0);
        drain();
        send(20, 0, 1'b1, 5, "R8", 1'b0);
        drain();
        send(30, 8, 1'b0, 7, "R8", 1'b0);
        drain();
        send(40, 13, 1'b1, 9, "R9", 1'b0);
        drain();
        send(50, 3, 1'b1, 11, "R5", 1'b1);
        drain();

        // R10: stray byte without start marker
        in_data = 8'h5A; in_sop = 1'b0; in_eop = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R10", "stray byte in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R10", "stray byte out_valid", out_valid, 0);
        @(posedge clk); #1;
        in_valid = 1'b0; in_eop = 1'b0;

        bp_en = 1'b1;
        send(235, 10, 1'b1, 13, "R11", 1'b0);
        send(17, 2, 1'b1, 15, "R7", 1'b0);
        send(18, 4, 1'b1, 17, "R6", 1'b0);
        send(25, 6, 1'b1, 19, "R7", 1'b0);
        drain();
        bp_en = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "idle after bursts", out_valid, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule